// File: doc/BRIEF.md
# Root Port Clock and Reset Bring-Up Sequencer

This block is a hardware state machine that takes one PCIe root port from a cold state to a running port without software polling. A single start pulse launches the sequence. The block first waits until the PHY reports its reference clock. It then opens a configuration-access window on the lane and runs two request/acknowledge handshakes with the lane logic, strictly one after the other. After both are acknowledged it closes the window and turns on the lane and port reference clocks. The endpoint reset is held for a minimum time after the clocks come up, then released. After a settling interval the block polls the port-ready status, and once the port is ready it removes the clock-gating overrides.

All timing counts a free-running microsecond tick input, so the sequence is independent of the core clock frequency. Every status wait samples its input only on every `POLL_US`-th tick and gives up after a bounded number of ticks. A timeout parks the block in a sticky error state that names the failed step until the next start pulse. Control and status pins are plain levels and pulses; the block has no data stream.

Top module: `rp_bringup_seq`

## Requirements
- R1: After reset `ep_reset_n` is 0, `lane_cfg_access`, `lane_req`, `lane_refclk_en`, `port_refclk_en`, `done`, `err` are 0, `err_step` is 0, and both gating-override outputs `refclk_gate_dis` and `appclk_gate_dis` are 1.
- R2: On entry to any status wait the poll phase restarts; the status input is sampled only on a tick whose poll phase is 0 (the first tick after entry, then every `POLL_US` ticks). The lane outputs stay 0 until `phy_refclk_ok` is seen on such a sample; a high value between samples has no effect.
- R3: `lane_cfg_access` is 1 exactly while the two handshakes run. `lane_req[0]` rises first; `lane_req[1]` rises only after `lane_ack[0]` is sampled high; the machine leaves the handshakes only after `lane_ack[1]` is sampled high. Once raised, both requests stay 1 until done or error.
- R4: A status wait that has not succeeded by its last tick (tick number `WAIT_TO_US` for the three clock waits, `READY_TO_US` for the ready wait) enters the error state with `err_step` 1 = PHY clock, 2 = ack 0, 3 = ack 1, 4 = port ready.
- R5: After `lane_ack[1]` is sampled, `lane_cfg_access` drops, `lane_refclk_en` becomes 2'b11 and `port_refclk_en` 1 in the same cycle, while `ep_reset_n` stays 0 until tick number `HOLD_US+1` after that.
- R6: `ep_reset_n` rises at the end of the hold; on tick number `SETTLE_US+1` after the release the ready wait begins, polling `port_ready`.
- R7: When `port_ready` is sampled high, `done` becomes 1 and `refclk_gate_dis` and `appclk_gate_dis` become 0 while all enables and requests stay 1; `refclk_gate_dis` is 0 only while `done` is 1.
- R8: The error state is sticky until a start pulse: `err` 1, `err_step` holds its code, every enable, request and access output is 0, `ep_reset_n` is 0 and both gating overrides are 1.
- R9: A start pulse while the sequence is between the PHY wait and the ready wait (inclusive) is ignored: no output changes because of it.
- R10: A start pulse in idle, done or error restarts the sequence at the PHY wait, clears `err` and sets `err_step` to 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| phy_refclk_ok | input | 1 | PHY reports its reference clock present |
| lane_ack | input | 2 | Lane acknowledges, bit 0 for request 0, bit 1 for request 1 |
| port_ready | input | 1 | Port reports ready |
| lane_cfg_access | output | 1 | Lane configuration-access window open |
| lane_req | output | 2 | Lane clock requests, bit 0 first |
| lane_refclk_en | output | 2 | Both lane reference-clock enables |
| port_refclk_en | output | 1 | Port reference-clock enable |
| ep_reset_n | output | 1 | Endpoint reset, 0 = held in reset |
| refclk_gate_dis | output | 1 | Reference-clock gating override, 0 = gating allowed |
| appclk_gate_dis | output | 1 | Application-clock gating override, 0 = gating allowed |
| done | output | 1 | Sequence finished with the port ready |
| err | output | 1 | Sequence stopped on a timeout |
| err_step | output | 3 | Failed step code while `err` is 1, else 0 |

## Verification
The sequence is driven with a tick on every cycle and with a tick on every third cycle, which separates counting in core cycles from counting in ticks and exposes off-by-one errors in the hold, settle and poll windows. Status inputs are raised late, raised between poll samples, or never raised: a one-cycle PHY status pulse off the poll phase must be ignored, while a never-raised input at each of the four waits must yield its own step code. A start pulse during the settle interval and restarts from done and from error show that only the idle-like states accept a start.

// File: rtl/rp_bringup_pkg.sv
package rp_bringup_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PHY,
    ST_ACK0,
    ST_ACK1,
    ST_HOLD,
    ST_SETTLE,
    ST_READY,
    ST_DONE,
    ST_FAIL
  } seq_state_t;

  localparam logic [2:0] STEP_NONE  = 3'd0;
  localparam logic [2:0] STEP_PHY   = 3'd1;
  localparam logic [2:0] STEP_ACK0  = 3'd2;
  localparam logic [2:0] STEP_ACK1  = 3'd3;
  localparam logic [2:0] STEP_READY = 3'd4;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rpbu_timer.sv
// Tick-based elapsed counter and poll phase, both cleared on every state change.
module rpbu_timer #(
  parameter int POLL_US = 100,
  parameter int CNT_W   = 18,
  parameter int PW      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             us_tick,
  output logic [CNT_W-1:0] elapsed,
  output logic             poll_due
);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed <= '0;
      phase_q <= '0;
    end else if (restart) begin
      elapsed <= '0;
      phase_q <= '0;
    end else if (us_tick) begin
      if (elapsed != '1) elapsed <= elapsed + 1'b1;
      if (phase_q == PW'(POLL_US - 1)) phase_q <= '0;
      else                             phase_q <= phase_q + 1'b1;
    end
  end

  assign poll_due = (phase_q == '0);

  // R2: the poll phase never leaves its window of POLL_US ticks
  a_r2_phase_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q <= PW'(POLL_US - 1));

  // R2: a state change restarts the poll phase at a sampling tick
  a_r2_restart_aligns: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> poll_due);

endmodule

// File: rtl/rpbu_ctrl.sv
// Sequencing state machine and the sticky failed-step record.
module rpbu_ctrl
  import rp_bringup_pkg::*;
#(
  parameter int WAIT_TO_US  = 50000,
  parameter int HOLD_US     = 100,
  parameter int SETTLE_US   = 100000,
  parameter int READY_TO_US = 250000,
  parameter int CNT_W       = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             us_tick,
  input  logic             phy_refclk_ok,
  input  logic [1:0]       lane_ack,
  input  logic             port_ready,
  input  logic [CNT_W-1:0] elapsed,
  input  logic             poll_due,
  output seq_state_t       state_q,
  output logic             restart,
  output logic [2:0]       err_step
);

  seq_state_t state_d;
  logic [2:0] step_d;
  logic       sample;
  logic       wait_last;
  logic       ready_last;
  logic       hold_end;
  logic       settle_end;
  logic       accepts_start;

  assign sample     = us_tick && poll_due;
  assign wait_last  = us_tick && (elapsed == CNT_W'(WAIT_TO_US - 1));
  assign ready_last = us_tick && (elapsed == CNT_W'(READY_TO_US - 1));
  assign hold_end   = us_tick && (elapsed == CNT_W'(HOLD_US));
  assign settle_end = us_tick && (elapsed == CNT_W'(SETTLE_US));
  assign accepts_start = (state_q == ST_IDLE) || (state_q == ST_DONE) ||
                         (state_q == ST_FAIL);

  always_comb begin
    state_d = state_q;
    step_d  = err_step;
    case (state_q)
      ST_IDLE, ST_DONE, ST_FAIL: begin
        if (start) begin
          state_d = ST_PHY;
          step_d  = STEP_NONE;
        end
      end
      ST_PHY: begin
        if (sample && phy_refclk_ok) begin
          state_d = ST_ACK0;
        end else if (wait_last) begin
          state_d = ST_FAIL;
          step_d  = STEP_PHY;
        end
      end
      ST_ACK0: begin
        if (sample && lane_ack[0]) begin
          state_d = ST_ACK1;
        end else if (wait_last) begin
          state_d = ST_FAIL;
          step_d  = STEP_ACK0;
        end
      end
      ST_ACK1: begin
        if (sample && lane_ack[1]) begin
          state_d = ST_HOLD;
        end else if (wait_last) begin
          state_d = ST_FAIL;
          step_d  = STEP_ACK1;
        end
      end
      ST_HOLD: begin
        if (hold_end) state_d = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (settle_end) state_d = ST_READY;
      end
      ST_READY: begin
        if (sample && port_ready) begin
          state_d = ST_DONE;
        end else if (ready_last) begin
          state_d = ST_FAIL;
          step_d  = STEP_READY;
        end
      end
      default: begin
        state_d = ST_IDLE;
        step_d  = STEP_NONE;
      end
    endcase
  end

  assign restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      err_step <= STEP_NONE;
    end else begin
      state_q  <= state_d;
      err_step <= step_d;
    end
  end

  // R4: in the error state the step code is one of the four defined codes
  a_r4_step_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL) |-> (err_step >= STEP_PHY && err_step <= STEP_READY));

  // R8: without a start the error state holds
  a_r8_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAIL && !start) |=> (state_q == ST_FAIL && $stable(err_step)));

  // R9: a start while busy never sends the machine back to the PHY wait
  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!accepts_start && state_q != ST_PHY && start) |=> (state_q != ST_PHY));

  // R10: an accepted start clears the step code
  a_r10_start_clears_step: assert property (@(posedge clk) disable iff (!rst_n)
    (accepts_start && start) |=> (state_q == ST_PHY && err_step == STEP_NONE));

endmodule

// File: rtl/rpbu_drive.sv
// Decodes the sequencing state into the port's control levels.
module rpbu_drive
  import rp_bringup_pkg::*;
(
  input  seq_state_t state_q,
  output logic       lane_cfg_access,
  output logic [1:0] lane_req,
  output logic [1:0] lane_refclk_en,
  output logic       port_refclk_en,
  output logic       ep_reset_n,
  output logic       refclk_gate_dis,
  output logic       appclk_gate_dis,
  output logic       done,
  output logic       err
);

  always_comb begin
    lane_cfg_access = 1'b0;
    lane_req        = 2'b00;
    lane_refclk_en  = 2'b00;
    port_refclk_en  = 1'b0;
    ep_reset_n      = 1'b0;
    refclk_gate_dis = 1'b1;
    appclk_gate_dis = 1'b1;
    done            = 1'b0;
    err             = 1'b0;
    case (state_q)
      ST_ACK0: begin
        lane_cfg_access = 1'b1;
        lane_req        = 2'b01;
      end
      ST_ACK1: begin
        lane_cfg_access = 1'b1;
        lane_req        = 2'b11;
      end
      ST_HOLD: begin
        lane_req       = 2'b11;
        lane_refclk_en = 2'b11;
        port_refclk_en = 1'b1;
      end
      ST_SETTLE, ST_READY: begin
        lane_req       = 2'b11;
        lane_refclk_en = 2'b11;
        port_refclk_en = 1'b1;
        ep_reset_n     = 1'b1;
      end
      ST_DONE: begin
        lane_req        = 2'b11;
        lane_refclk_en  = 2'b11;
        port_refclk_en  = 1'b1;
        ep_reset_n      = 1'b1;
        refclk_gate_dis = 1'b0;
        appclk_gate_dis = 1'b0;
        done            = 1'b1;
      end
      ST_FAIL: begin
        err = 1'b1;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
  import rp_bringup_pkg::*;
#(
  parameter int POLL_US     = 100,
  parameter int WAIT_TO_US  = 50000,
  parameter int HOLD_US     = 100,
  parameter int SETTLE_US   = 100000,
  parameter int READY_TO_US = 250000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       us_tick,
  input  logic       phy_refclk_ok,
  input  logic [1:0] lane_ack,
  input  logic       port_ready,
  output logic       lane_cfg_access,
  output logic [1:0] lane_req,
  output logic [1:0] lane_refclk_en,
  output logic       port_refclk_en,
  output logic       ep_reset_n,
  output logic       refclk_gate_dis,
  output logic       appclk_gate_dis,
  output logic       done,
  output logic       err,
  output logic [2:0] err_step
);

  localparam int CNT_MAX = max_of(max_of(WAIT_TO_US, HOLD_US),
                                  max_of(SETTLE_US, READY_TO_US)) + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int PW      = (POLL_US > 1) ? $clog2(POLL_US) : 1;

  seq_state_t       state_q;
  logic             restart;
  logic [CNT_W-1:0] elapsed;
  logic             poll_due;

  rpbu_timer #(
    .POLL_US (POLL_US),
    .CNT_W   (CNT_W),
    .PW      (PW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (restart),
    .us_tick  (us_tick),
    .elapsed  (elapsed),
    .poll_due (poll_due)
  );

  rpbu_ctrl #(
    .WAIT_TO_US  (WAIT_TO_US),
    .HOLD_US     (HOLD_US),
    .SETTLE_US   (SETTLE_US),
    .READY_TO_US (READY_TO_US),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .us_tick       (us_tick),
    .phy_refclk_ok (phy_refclk_ok),
    .lane_ack      (lane_ack),
    .port_ready    (port_ready),
    .elapsed       (elapsed),
    .poll_due      (poll_due),
    .state_q       (state_q),
    .restart       (restart),
    .err_step      (err_step)
  );

  rpbu_drive u_drive (
    .state_q         (state_q),
    .lane_cfg_access (lane_cfg_access),
    .lane_req        (lane_req),
    .lane_refclk_en  (lane_refclk_en),
    .port_refclk_en  (port_refclk_en),
    .ep_reset_n      (ep_reset_n),
    .refclk_gate_dis (refclk_gate_dis),
    .appclk_gate_dis (appclk_gate_dis),
    .done            (done),
    .err             (err)
  );

  // R2: the lane window opens only after the PHY clock status was high
  a_r2_lane_after_phy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_cfg_access) |-> $past(phy_refclk_ok));

  // R3: request 1 rises only after acknowledge 0 was high
  a_r3_req1_after_ack0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lane_req[1]) |-> ($past(lane_ack[0]) && lane_req[0]));

  // R5: the endpoint leaves reset only with every reference clock on
  a_r5_release_needs_clocks: assert property (@(posedge clk) disable iff (!rst_n)
    ep_reset_n |-> (lane_refclk_en == 2'b11 && port_refclk_en && !lane_cfg_access));

  // R6: done rises only after port ready was high
  a_r6_ready_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(port_ready) && $past(ep_reset_n)));

  // R7: gating overrides are removed only in the done state
  a_r7_ungate_only_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!refclk_gate_dis || !appclk_gate_dis) |-> done);

endmodule

// File: tb/rp_bringup_seq_test.sv
module rp_bringup_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_POLL   = 3;
  localparam int P_WAIT   = 12;
  localparam int P_HOLD   = 5;
  localparam int P_SETTLE = 8;
  localparam int P_RDY    = 15;

  // model states
  localparam int M_IDLE = 0, M_PHY = 1, M_ACK0 = 2, M_ACK1 = 3, M_HOLD = 4,
                 M_SETTLE = 5, M_READY = 6, M_DONE = 7, M_FAIL = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic phy_refclk_ok = 1'b0;
  logic [1:0] lane_ack = 2'b00;
  logic port_ready = 1'b0;
  logic us_tick;
  logic lane_cfg_access, port_refclk_en, ep_reset_n;
  logic refclk_gate_dis, appclk_gate_dis, done, err;
  logic [1:0] lane_req, lane_refclk_en;
  logic [2:0] err_step;

  int cyc = 0;
  bit tick_every = 1'b1;
  int n_tests = 0;
  int n_fail = 0;
  bit live = 1'b0;

  int m_st = M_IDLE;
  int m_el = 0;
  int m_poll = 0;
  int m_step = 0;
  int m_ns;
  bit m_smp;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign us_tick = tick_every ? 1'b1 : ((cyc % 3) == 0);

  rp_bringup_seq #(
    .POLL_US(P_POLL), .WAIT_TO_US(P_WAIT), .HOLD_US(P_HOLD),
    .SETTLE_US(P_SETTLE), .READY_TO_US(P_RDY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .us_tick(us_tick),
    .phy_refclk_ok(phy_refclk_ok), .lane_ack(lane_ack), .port_ready(port_ready),
    .lane_cfg_access(lane_cfg_access), .lane_req(lane_req),
    .lane_refclk_en(lane_refclk_en), .port_refclk_en(port_refclk_en),
    .ep_reset_n(ep_reset_n), .refclk_gate_dis(refclk_gate_dis),
    .appclk_gate_dis(appclk_gate_dis), .done(done), .err(err), .err_step(err_step)
  );

  // Behavioural reference: requirement-level timing in plain integers.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = M_IDLE; m_el = 0; m_poll = 0; m_step = 0;
    end else begin
      m_ns = m_st;
      m_smp = us_tick && (m_poll == 0);
      case (m_st)
        M_IDLE, M_DONE, M_FAIL: if (start) begin m_ns = M_PHY; m_step = 0; end
        M_PHY:
          if (m_smp && phy_refclk_ok) m_ns = M_ACK0;
          else if (us_tick && m_el == P_WAIT - 1) begin m_ns = M_FAIL; m_step = 1; end
        M_ACK0:
          if (m_smp && lane_ack[0]) m_ns = M_ACK1;
          else if (us_tick && m_el == P_WAIT - 1) begin m_ns = M_FAIL; m_step = 2; end
        M_ACK1:
          if (m_smp && lane_ack[1]) m_ns = M_HOLD;
          else if (us_tick && m_el == P_WAIT - 1) begin m_ns = M_FAIL; m_step = 3; end
        M_HOLD:   if (us_tick && m_el == P_HOLD) m_ns = M_SETTLE;
        M_SETTLE: if (us_tick && m_el == P_SETTLE) m_ns = M_READY;
        M_READY:
          if (m_smp && port_ready) m_ns = M_DONE;
          else if (us_tick && m_el == P_RDY - 1) begin m_ns = M_FAIL; m_step = 4; end
        default: m_ns = M_IDLE;
      endcase
      if (m_ns != m_st) begin
        m_el = 0; m_poll = 0;
      end else if (us_tick) begin
        m_el = m_el + 1;
        m_poll = (m_poll == P_POLL - 1) ? 0 : m_poll + 1;
      end
      m_st = m_ns;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (live) begin
      bit in_hs, clk_on, rel, is_done;
      in_hs   = (m_st == M_ACK0 || m_st == M_ACK1);
      clk_on  = (m_st >= M_HOLD && m_st <= M_DONE);
      rel     = (m_st >= M_SETTLE && m_st <= M_DONE);
      is_done = (m_st == M_DONE);
      chk("R3 cfg access", int'(lane_cfg_access), int'(in_hs));
      chk("R3 lane requests", int'(lane_req),
          (m_st == M_ACK0) ? 1 : ((m_st >= M_ACK1 && m_st <= M_DONE) ? 3 : 0));
      chk("R5 lane clock enables", int'(lane_refclk_en), clk_on ? 3 : 0);
      chk("R5 port clock enable", int'(port_refclk_en), int'(clk_on));
      chk("R6 endpoint reset", int'(ep_reset_n), int'(rel));
      chk("R7 gating overrides", int'({refclk_gate_dis, appclk_gate_dis}), is_done ? 0 : 3);
      chk("R7 done flag", int'(done), int'(is_done));
      chk("R8 err flag", int'(err), int'(m_st == M_FAIL));
      chk("R4 step code", int'(err_step), m_step);
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_model(input int st, input string tag);
    int n = 0;
    while (m_st != st && n < 400) begin @(negedge clk); n++; end
    chk({tag, " reached state"}, m_st, st);
  endtask

  task automatic clear_inputs();
    @(negedge clk);
    phy_refclk_ok = 1'b0; lane_ack = 2'b00; port_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 ep_reset_n", int'(ep_reset_n), 0);
    chk("R1 enables", int'({lane_cfg_access, lane_req, lane_refclk_en, port_refclk_en}), 0);
    chk("R1 gating overrides", int'({refclk_gate_dis, appclk_gate_dis}), 3);
    chk("R1 flags", int'({done, err, err_step}), 0);
    rst_n = 1'b1;
    live = 1'b1;

    // Normal run, tick every cycle, late acknowledges, start during settle (R9)
    phy_refclk_ok = 1'b1;
    pulse_start();
    wait_model(M_ACK0, "R3 ack0 wait");
    repeat (5) @(negedge clk);
    lane_ack[0] = 1'b1;
    wait_model(M_ACK1, "R3 ack1 wait");
    chk("R3 req1 after ack0", int'(lane_req), 3);
    repeat (4) @(negedge clk);
    lane_ack[1] = 1'b1;
    wait_model(M_HOLD, "R5 hold");
    chk("R5 reset held during hold", int'(ep_reset_n), 0);
    wait_model(M_SETTLE, "R6 settle");
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R9 start ignored, reset still released", int'(ep_reset_n), 1);
    chk("R9 start ignored, window closed", int'(lane_cfg_access), 0);
    port_ready = 1'b1;
    wait_model(M_DONE, "R7 done");
    chk("R7 gating cleared", int'({refclk_gate_dis, appclk_gate_dis}), 0);
    chk("R7 enables kept", int'({lane_refclk_en, port_refclk_en}), 7);
    clear_inputs();

    // Sparse ticks, off-phase PHY pulse ignored (R2)
    tick_every = 1'b0;
    pulse_start();
    repeat (4) @(negedge clk);
    while ((cyc % 3) == 0) @(negedge clk);
    phy_refclk_ok = 1'b1;
    @(negedge clk);
    phy_refclk_ok = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2 off-phase status ignored", int'(lane_cfg_access), 0);
    phy_refclk_ok = 1'b1;
    lane_ack = 2'b11;
    wait_model(M_READY, "R6 ready wait sparse");
    repeat (7) @(negedge clk);
    port_ready = 1'b1;
    wait_model(M_DONE, "R7 done sparse");
    clear_inputs();
    tick_every = 1'b1;

    // Restart from done, PHY never reports (R4 step 1, R8 sticky)
    pulse_start();
    wait_model(M_FAIL, "R4 phy timeout");
    chk("R4 step code phy", int'(err_step), 1);
    repeat (20) @(negedge clk);
    chk("R8 error sticky", int'(err), 1);
    chk("R8 safe outputs", int'({lane_refclk_en, port_refclk_en, ep_reset_n}), 0);

    // Restart from error, ack0 never (R10, R4 step 2)
    phy_refclk_ok = 1'b1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R10 err cleared on start", int'(err), 0);
    chk("R10 step cleared on start", int'(err_step), 0);
    wait_model(M_FAIL, "R4 ack0 timeout");
    chk("R4 step code ack0", int'(err_step), 2);

    // ack1 never (R4 step 3)
    lane_ack = 2'b01;
    pulse_start();
    wait_model(M_FAIL, "R4 ack1 timeout");
    chk("R4 step code ack1", int'(err_step), 3);

    // ready never (R4 step 4)
    lane_ack = 2'b11;
    pulse_start();
    wait_model(M_FAIL, "R4 ready timeout");
    chk("R4 step code ready", int'(err_step), 4);
    chk("R8 reset reasserted", int'(ep_reset_n), 0);

    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule